// File: doc/BRIEF.md
# Register Stack Frame Engine

This block renames the stacked part of a 128-entry register file as a chain of procedure frames laid over a circular physical region of 96 entries. Registers 0 to 31 are global and pass through untouched. A stacked logical number 32+i is translated to physical index 32 + ((base + i) mod 96), where base is the start of the current frame. Each frame is sized explicitly. Its first `cur_sol` registers are the inputs and locals, and the rest up to `cur_sof` are outputs. On a call, the caller's outputs become the callee's inputs without any copying.

When a resize asks for more registers than the circular region holds, the oldest resident registers of older frames are spilled to a backing store in memory. When a return needs caller registers that were spilled, they are filled back in last-in-first-out order. Both kinds of transfer run in the background, one register per cycle in which the core grants the memory port. While transfers are pending, the stacked region is stalled. The core keeps the frame marker that a call emits and hands it back on the matching return.

Top module: `rse_frame`

## Requirements
- R1: After reset the frame base, the local size and the frame size are 0, `bsp` equals BSP_BASE, `ready` is 1 and `mem_req` is 0.
- R2: `lreg` below 32 gives `preg` = `lreg` with `preg_ok` = 1. For `lreg` = 32+i with i < `cur_sof`, the outputs are `preg` = 32 + ((`cur_bof` + i) mod 96) and `preg_ok` = 1 while ready. For i >= `cur_sof`, `preg_ok` is 0.
- R3: An accepted resize (`op_kind` = 0) sets the local size to `op_sol` and the frame size to `op_sof`, and leaves the base unchanged.
- R4: An accepted call (`op_kind` = 1) makes the base (base + local size) mod 96, the frame size (frame size − local size) and the local size 0. It also presents the caller's local and frame sizes on `pfm_sol`/`pfm_sof`.
- R5: An accepted return (`op_kind` = 2) takes the caller's marker on `op_sol`/`op_sof`. It makes the base (base − `op_sol`) mod 96 and restores both sizes.
- R6: If a resize makes the resident older registers plus the new frame size exceed 96, the excess number of registers is spilled, oldest first. Each spill has `mem_we` = 1, `mem_addr` = `bsp` and `mem_preg` = the oldest resident physical index, and `bsp` then grows by 8.
- R7: If a return needs more caller locals than are still resident, the missing count is filled, most recently spilled first. Each fill has `mem_we` = 0, `mem_addr` = `bsp` − 8, and `mem_preg` equal to the register stored at that address, and `bsp` then drops by 8.
- R8: A transfer advances only in a cycle with `mem_gnt` = 1. Without a grant, `mem_req` stays high and `bsp` holds.
- R9: While transfers are pending, `ready` is 0, stacked lookups give `preg_ok` = 0, and operations are ignored. `op_kind` = 3 has no effect even when ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| op_valid | input | 1 | frame operation strobe |
| op_kind | input | 2 | 0 resize, 1 call, 2 return, 3 none |
| op_sol | input | 7 | local size (resize) or caller local size (return) |
| op_sof | input | 7 | frame size (resize) or caller frame size (return) |
| ready | output | 1 | current frame fully resident, operations accepted |
| cur_bof | output | 7 | current frame base within the stacked region |
| cur_sol | output | 7 | current inputs-plus-locals count |
| cur_sof | output | 7 | current frame size |
| pfm_sol | output | 7 | marker: caller local size of the last call |
| pfm_sof | output | 7 | marker: caller frame size of the last call |
| lreg | input | 7 | logical register number to translate |
| preg | output | 7 | physical register index |
| preg_ok | output | 1 | translation valid |
| mem_req | output | 1 | spill or fill pending |
| mem_we | output | 1 | 1 spill (write), 0 fill (read) |
| mem_addr | output | 32 | backing store byte address |
| mem_preg | output | 7 | physical register being transferred |
| mem_gnt | input | 1 | memory port idle this cycle |
| bsp | output | 32 | backing store pointer |

## Verification
Translation is combinational, so `preg` and `preg_ok` are checked 1 ns after `lreg` changes. Frame state, `ready` and the transfer request are due one edge after the operation strobe, and each `bsp` step is due one edge after a granted cycle. The bench drives inputs at a falling edge and compares at the next falling edge. That leaves exactly one rising edge between stimulus and check. A reference model advances only for the cycles in which it applied a grant. Spilled register numbers are recorded by address, so that each fill is checked against the register that was actually stored there.

// File: rtl/rse_frame.sv
module rse_frame #(
  parameter int NLOW = 32,
  parameter int NSTK = 96,
  parameter int AW = 32,
  parameter logic [AW-1:0] BSP_BASE = 32'h1000,
  localparam int W = $clog2(NLOW + NSTK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [W-1:0]  op_sol,
  input  logic [W-1:0]  op_sof,
  output logic          ready,
  output logic [W-1:0]  cur_bof,
  output logic [W-1:0]  cur_sol,
  output logic [W-1:0]  cur_sof,
  output logic [W-1:0]  pfm_sol,
  output logic [W-1:0]  pfm_sof,
  input  logic [W-1:0]  lreg,
  output logic [W-1:0]  preg,
  output logic          preg_ok,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_preg,
  input  logic          mem_gnt,
  output logic [AW-1:0] bsp
);
  function automatic logic [W-1:0] wrap(input logic [W:0] v);
    return (int'(v) >= NSTK) ? W'(int'(v) - NSTK) : W'(v);
  endfunction

  logic [W-1:0] nd, pend;
  logic         fill;
  logic [W-1:0] idx;
  logic         in_stk, acc, step;

  assign ready   = (pend == '0);
  assign mem_req = !ready;
  assign mem_we  = !fill;
  assign acc     = op_valid && ready;
  assign step    = mem_req && mem_gnt;

  assign mem_addr = fill ? bsp - AW'(8) : bsp;
  assign mem_preg = W'(NLOW) + (fill ? wrap({1'b0, cur_bof} + {1'b0, pend} - 1'b1)
                                     : wrap(W'(1)'(0) + {1'b0, cur_bof} + (W+1)'(NSTK) - {1'b0, nd}));

  assign in_stk  = int'(lreg) >= NLOW;
  assign idx     = lreg - W'(NLOW);
  assign preg    = in_stk ? W'(NLOW) + wrap({1'b0, cur_bof} + {1'b0, idx}) : lreg;
  assign preg_ok = !in_stk || (ready && idx < cur_sof);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bof <= '0; cur_sol <= '0; cur_sof <= '0;
      pfm_sol <= '0; pfm_sof <= '0;
      nd <= '0; pend <= '0; fill <= 1'b0;
      bsp <= BSP_BASE;
    end else if (acc) begin
      case (op_kind)
        2'd0: begin
          cur_sol <= op_sol;
          cur_sof <= op_sof;
          if (int'(nd) + int'(op_sof) > NSTK) begin
            pend <= W'(int'(nd) + int'(op_sof) - NSTK);
            fill <= 1'b0;
          end
        end
        2'd1: begin
          cur_bof <= wrap({1'b0, cur_bof} + {1'b0, cur_sol});
          nd      <= nd + cur_sol;
          cur_sof <= cur_sof - cur_sol;
          cur_sol <= '0;
          pfm_sol <= cur_sol;
          pfm_sof <= cur_sof;
        end
        2'd2: begin
          cur_bof <= wrap({1'b0, cur_bof} + (W+1)'(NSTK) - {1'b0, op_sol});
          cur_sol <= op_sol;
          cur_sof <= op_sof;
          if (op_sol > nd) begin
            nd   <= '0;
            pend <= op_sol - nd;
            fill <= 1'b1;
          end else begin
            nd <= nd - op_sol;
          end
        end
        default: ;
      endcase
    end else if (step) begin
      pend <= pend - 1'b1;
      if (fill) bsp <= bsp - AW'(8);
      else begin
        bsp <= bsp + AW'(8);
        nd  <= nd - 1'b1;
      end
    end
  end
endmodule

module rse_frame_chk #(
  parameter int NLOW = 32,
  parameter int NSTK = 96,
  parameter int AW = 32,
  parameter int W = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [1:0]    op_kind,
  input logic          ready,
  input logic [W-1:0]  cur_bof,
  input logic [W-1:0]  cur_sol,
  input logic [W-1:0]  cur_sof,
  input logic [W-1:0]  lreg,
  input logic [W-1:0]  preg,
  input logic          preg_ok,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic [AW-1:0] bsp
);
  logic [W:0] call_sum;
  assign call_sum = {1'b0, cur_bof} + {1'b0, cur_sol};

  a_r6_spill_bsp_up: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && mem_we |=> bsp == $past(bsp) + AW'(8));
  a_r7_fill_bsp_down: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && !mem_we |=> bsp == $past(bsp) - AW'(8));
  a_r8_hold_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(bsp));
  a_r9_stall_ignores_ops: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(cur_bof) && $stable(cur_sol) && $stable(cur_sof));
  a_r9_stall_hides_stacked: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && int'(lreg) >= NLOW |-> !preg_ok);
  a_r2_low_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    int'(lreg) < NLOW |-> preg_ok && preg == lreg);
  a_r4_call_base: assert property (@(posedge clk) disable iff (!rst_n)
    ready && op_valid && op_kind == 2'd1 |=>
      cur_bof == (int'($past(call_sum)) >= NSTK ? W'(int'($past(call_sum)) - NSTK) : W'($past(call_sum))));
endmodule

bind rse_frame rse_frame_chk #(.NLOW(NLOW), .NSTK(NSTK), .AW(AW), .W(W)) u_chk (.*);

// File: tb/sim_rse_frame.sv
module sim_rse_frame;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, mem_gnt = 0;
  logic [1:0] op_kind = 0;
  logic [6:0] op_sol = 0, op_sof = 0, lreg = 0;
  logic ready, preg_ok, mem_req, mem_we;
  logic [6:0] cur_bof, cur_sol, cur_sof, pfm_sol, pfm_sof, preg, mem_preg;
  logic [31:0] mem_addr, bsp;

  rse_frame u0 (.*);

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int m_bof, m_sol, m_sof, m_nd, m_pend, m_fill, m_bsp;
  int stk_sol[64], stk_sof[64];
  int depth = 0;
  int store[int];

  function automatic int wr(int v);
    return v % 96;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(string tag);
    chk(cur_bof == m_bof, {tag, " bof"}, cur_bof, m_bof);
    chk(cur_sol == m_sol, {tag, " sol"}, cur_sol, m_sol);
    chk(cur_sof == m_sof, {tag, " sof"}, cur_sof, m_sof);
    chk(ready == (m_pend == 0), {tag, " ready R9"}, ready, m_pend == 0);
  endtask

  task automatic xlate(int l);
    int i;
    lreg = 7'(l);
    #1;
    if (l < 32) begin
      chk(preg_ok && preg == 7'(l), "R2 global", preg, l);
    end else begin
      i = l - 32;
      chk(preg_ok == (m_pend == 0 && i < m_sof), "R2/R9 valid", preg_ok, m_pend == 0 && i < m_sof);
      if (m_pend == 0 && i < m_sof)
        chk(preg == 7'(32 + wr(m_bof + i)), "R2 stacked", preg, 32 + wr(m_bof + i));
    end
  endtask

  task automatic do_op(int k, int s, int f);
    op_valid = 1; op_kind = 2'(k); op_sol = 7'(s); op_sof = 7'(f);
    @(negedge clk);
    op_valid = 0;
    case (k)
      0: begin
        m_sol = s; m_sof = f;
        if (m_nd + f > 96) begin m_pend = m_nd + f - 96; m_fill = 0; end
      end
      1: begin
        chk(pfm_sol == 7'(m_sol) && pfm_sof == 7'(m_sof), "R4 marker", pfm_sol, m_sol);
        m_bof = wr(m_bof + m_sol); m_nd += m_sol; m_sof -= m_sol; m_sol = 0;
      end
      2: begin
        m_bof = wr(m_bof + 96 - s); m_sol = s; m_sof = f;
        if (s > m_nd) begin m_pend = s - m_nd; m_nd = 0; m_fill = 1; end
        else m_nd -= s;
      end
      default: ;
    endcase
    chk_state(k == 0 ? "R3" : k == 1 ? "R4" : k == 2 ? "R5" : "R9 nop");
    chk(mem_req == (m_pend != 0), "R6/R7 req", mem_req, m_pend != 0);
  endtask

  task automatic drain();
    int e_pr, e_ad;
    bit g, inj;
    while (m_pend > 0) begin
      if (m_fill) begin e_ad = m_bsp - 8; e_pr = 32 + wr(m_bof + m_pend - 1); end
      else begin e_ad = m_bsp; e_pr = 32 + wr(m_bof + 96 - m_nd); end
      chk(mem_req && !ready, "R9 stall", ready, 0);
      chk(mem_we == !m_fill, m_fill ? "R7 dir" : "R6 dir", mem_we, !m_fill);
      chk(mem_addr == 32'(e_ad), m_fill ? "R7 addr" : "R6 addr", mem_addr, e_ad);
      chk(mem_preg == 7'(e_pr), m_fill ? "R7 preg" : "R6 preg", mem_preg, e_pr);
      if (m_fill)
        chk(store.exists(e_ad) && int'(mem_preg) == store[e_ad], "R7 lifo", mem_preg, store.exists(e_ad) ? store[e_ad] : -1);
      if ($urandom % 8 == 0) xlate(32 + $urandom % 96);
      g = ($urandom % 3) != 0;
      inj = ($urandom % 4) == 0;
      mem_gnt = g;
      if (inj) begin
        op_valid = 1; op_kind = 2'($urandom); op_sol = 7'($urandom % 97); op_sof = 7'(96);
      end
      @(negedge clk);
      mem_gnt = 0; op_valid = 0;
      if (g) begin
        m_pend--;
        if (m_fill) m_bsp -= 8;
        else begin store[m_bsp] = e_pr; m_bsp += 8; m_nd--; end
      end else begin
        chk(mem_req == 1'b1, "R8 hold req", mem_req, 1);
      end
      chk(bsp == 32'(m_bsp), "R8 bsp", bsp, m_bsp);
      if (inj) chk_state("R9 ignored");
    end
    chk(ready && !mem_req, "R9 resident", ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd11));
    m_bof = 0; m_sol = 0; m_sof = 0; m_nd = 0; m_pend = 0; m_fill = 0; m_bsp = 32'h1000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_state("R1");
    chk(bsp == 32'h1000 && !mem_req, "R1 bsp", bsp, 32'h1000);

    do_op(0, 96, 96); drain();
    xlate(32); xlate(127); xlate(5);
    do_op(1, 0, 0);
    stk_sol[depth] = 96; stk_sof[depth] = 96; depth++;
    do_op(0, 10, 10); drain();
    xlate(41); xlate(42);
    do_op(3, 5, 5);
    depth--; do_op(2, stk_sol[depth], stk_sof[depth]); drain();
    xlate(32 + 95);

    for (int n = 0; n < 300; n++) begin
      int r, s, f;
      r = $urandom % 10;
      if (depth > 0 && r < 3) begin
        depth--;
        do_op(2, stk_sol[depth], stk_sof[depth]);
      end else if (r < 6 && depth < 64) begin
        stk_sol[depth] = m_sol; stk_sof[depth] = m_sof; depth++;
        do_op(1, 0, 0);
      end else if (r == 6) begin
        do_op(3, $urandom % 97, $urandom % 97);
      end else begin
        f = $urandom % 97; s = $urandom % (f + 1);
        do_op(0, s, f);
      end
      drain();
      xlate($urandom % 128);
      xlate(32 + $urandom % 96);
    end
    while (depth > 0) begin
      depth--;
      do_op(2, stk_sol[depth], stk_sof[depth]);
      drain();
    end
    chk(bsp == 32'(m_bsp), "R7 final bsp", bsp, m_bsp);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule